// File: doc/BRIEF.md
# Floating-Point Interlock Stall Unit

This block sits in the issue stage of an in-order pipeline whose floating-point and integer register files are separate. Every cycle it may be offered one decoded instruction: a class code, a destination register index and two source register indices. It remembers how long ago each floating-point register was last written by an instruction still in flight. It holds the offered instruction whenever one of its floating-point source operands would be read before the producing instruction can supply it.

The wait is not a single fixed load-use gap. It is chosen by the pair of producer class and consumer class. A floating-point arithmetic result feeding another arithmetic operation waits longest. The same result feeding the data operand of a store waits one cycle less. A load feeding arithmetic waits a single cycle, and a load feeding a store does not wait. While an instruction is held it is not consumed, and an empty slot with no register write leaves the stage. The issue output also marks the slot that follows a branch, which is the branch delay slot.

Top module: `fp_interlock`

## Requirements
- R1: After synchronous reset, no source register is considered busy. The first instruction offered, of any class, is accepted without a stall, and the issue output shows no valid instruction until something has been accepted.
- R2: Class codes are 0 integer op, 1 FP arithmetic, 2 FP load, 3 FP store, 4 branch; codes 5 to 7 behave as integer ops. An FP arithmetic op (reads FP src_a and src_b) that reads the destination of an FP arithmetic op accepted in cycle t is stalled in cycles t+1 to t+3 and accepted in cycle t+4.
- R3: An FP store uses src_b as its FP data register and src_a as an integer address register. If that data register was written by an FP arithmetic op, the store is stalled for exactly 2 cycles when it is offered right after that op.
- R4: An FP arithmetic op reading the destination of an FP load is stalled for exactly 1 cycle when it is offered right after the load.
- R5: An FP store whose data register was written by the FP load just before it is accepted with no stall.
- R6: Instructions whose FP sources have no in-flight producer, including random streams checked against the class-pair latencies, are accepted back to back with no stall.
- R7: Integer ops, branches and the store's address operand never stall. A write by an integer op to index n never delays an FP reader of FP register n.
- R8: While stall is high, in_ready is low and the issue output in the next cycle has iss_valid low.
- R9: An instruction accepted in cycle t appears in cycle t+1 on iss_valid, iss_cls and iss_dst.
- R10: iss_dslot is high in the cycle after the issue output carried a branch, whether that slot holds an instruction or an empty slot.
- R11: A newer FP producer of a register replaces the older one. The reader's wait is counted from the newer producer's acceptance and follows the newer producer's class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_cls | input | 3 | Class code of the offered instruction (see R2) |
| in_dst | input | RW | Destination register index |
| in_src_a | input | RW | First source index (FP for arithmetic, integer address for stores) |
| in_src_b | input | RW | Second source index (FP for arithmetic, FP data for stores) |
| in_ready | output | 1 | Offered instruction is consumed at the next edge |
| stall | output | 1 | Offered instruction is held because of an FP operand hazard |
| iss_valid | output | 1 | Issue slot carries an instruction (low for an empty slot) |
| iss_cls | output | 3 | Class code of the issued instruction |
| iss_dst | output | RW | Destination index of the issued instruction |
| iss_dslot | output | 1 | Issue slot follows a branch slot |

## Verification
The in-line properties assume that the upstream stage keeps an instruction steady on its inputs until in_ready is seen. They also assume that the latency parameters give the arithmetic consumer the longest wait for each producer class. The bench only replaces an offered instruction after it has been accepted. It draws register indices from a small pool of four, so producer-consumer pairs and overwrites of in-flight registers happen often. All five class codes appear in the random stream, mixed with idle cycles. Directed sequences first cover each class pair, integer aliasing, back-to-back branches and both kinds of producer replacement.

// File: rtl/ilk_pkg.sv
// ilk_pkg: shared class encoding and operand-use helpers for the
// floating-point interlock unit. Assumes a 3-bit class code; codes not
// listed fall back to integer behaviour (no FP operands, no FP write).
package ilk_pkg;

    typedef enum logic [2:0] {
        CL_INT  = 3'd0,
        CL_FALU = 3'd1,
        CL_FLD  = 3'd2,
        CL_FST  = 3'd3,
        CL_BR   = 3'd4
    } icls_e;

    // True when the class writes an FP register at issue.
    function automatic logic writes_fp(icls_e c);
        return (c == CL_FALU) || (c == CL_FLD);
    endfunction

    // True when operand A is an FP register read.
    function automatic logic reads_fp_a(icls_e c);
        return (c == CL_FALU);
    endfunction

    // True when operand B is an FP register read.
    function automatic logic reads_fp_b(icls_e c);
        return (c == CL_FALU) || (c == CL_FST);
    endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
// ilk_scoreboard: one down-counter and one producer-kind bit per FP register.
// On a write the counter takes the latency the producer owes an arithmetic
// consumer; it then counts down to zero by one per cycle.
// Assumes at most one FP write per cycle.
module ilk_scoreboard #(
    parameter int NREG = 32,
    parameter int CW   = 2,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RW-1:0]            wr_idx,
    input  logic [CW-1:0]            wr_lat,
    input  logic                     wr_ld,
    output logic [NREG-1:0][CW-1:0]  cnt,
    output logic [NREG-1:0]          is_ld
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (wr_idx == RW'(g));

        // Reload on a write, otherwise count toward zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[g]   <= '0;
                is_ld[g] <= 1'b0;
            end else if (hit) begin
                cnt[g]   <= wr_lat;
                is_ld[g] <= wr_ld;
            end else if (cnt[g] != '0) begin
                cnt[g]   <= cnt[g] - 1'b1;
            end
        end

        AST_CNT_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] != '0 && !hit) |=> (cnt[g] == CW'($past(cnt[g]) - 1'b1))); // R2
        AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == '0 && !hit) |=> $stable(cnt[g])); // R6
    end

endmodule

// File: rtl/ilk_hazard.sv
// ilk_hazard: decides whether the offered instruction must wait.
// A source is busy when its counter exceeds the slack allowed for the
// consumer kind: zero slack for arithmetic consumers, and the difference
// between the arithmetic and store latencies for store data.
// Assumes LAT_AA >= LAT_AS and LAT_LA >= LAT_LS.
module ilk_hazard
    import ilk_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int CW     = 2,
    parameter int LAT_AA = 3,
    parameter int LAT_AS = 2,
    parameter int LAT_LA = 1,
    parameter int LAT_LS = 0,
    localparam int RW    = $clog2(NREG)
) (
    input  logic                     in_valid,
    input  icls_e                    cls,
    input  logic [RW-1:0]            src_a,
    input  logic [RW-1:0]            src_b,
    input  logic [NREG-1:0][CW-1:0]  cnt,
    input  logic [NREG-1:0]          is_ld,
    output logic                     hazard
);

    localparam logic [CW-1:0] SLACK_AS = CW'(LAT_AA - LAT_AS);
    localparam logic [CW-1:0] SLACK_LS = CW'(LAT_LA - LAT_LS);

    logic busy_a, busy_b;
    logic [CW-1:0] slack_b;

    // Slack for operand B depends on consumer kind and producer kind.
    always_comb begin
        slack_b = '0;
        if (cls == CL_FST)
            slack_b = is_ld[src_b] ? SLACK_LS : SLACK_AS;
    end

    // Per-operand busy tests and the combined hold decision.
    always_comb begin
        busy_a = reads_fp_a(cls) && (cnt[src_a] != '0);
        busy_b = reads_fp_b(cls) && (cnt[src_b] > slack_b);
        hazard = in_valid && (busy_a || busy_b);
    end

endmodule

// File: rtl/ilk_issue_reg.sv
// ilk_issue_reg: the issue-slot register. Captures an accepted instruction
// or an empty slot, and flags the slot that follows a branch slot.
module ilk_issue_reg
    import ilk_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc,
    input  icls_e          cls,
    input  logic [RW-1:0]  dst,
    output logic           iss_valid,
    output icls_e          iss_cls,
    output logic [RW-1:0]  iss_dst,
    output logic           iss_dslot
);

    // Load the slot; an empty slot carries no class and no destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_cls   <= CL_INT;
            iss_dst   <= '0;
            iss_dslot <= 1'b0;
        end else begin
            iss_valid <= acc;
            iss_cls   <= acc ? cls : CL_INT;
            iss_dst   <= acc ? dst : '0;
            iss_dslot <= iss_valid && (iss_cls == CL_BR);
        end
    end

endmodule

// File: rtl/fp_interlock.sv
// fp_interlock: issue-stage interlock for a split integer / FP pipeline.
// Holds the offered instruction while an FP source is not yet ready for
// its consumer kind, and sends an empty slot downstream meanwhile.
// Assumes the offering stage keeps an instruction steady until in_ready.
module fp_interlock
    import ilk_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int LAT_AA = 3,
    parameter int LAT_AS = 2,
    parameter int LAT_LA = 1,
    parameter int LAT_LS = 0,
    localparam int RW    = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     in_cls,
    input  logic [RW-1:0]  in_dst,
    input  logic [RW-1:0]  in_src_a,
    input  logic [RW-1:0]  in_src_b,
    output logic           in_ready,
    output logic           stall,
    output logic           iss_valid,
    output logic [2:0]     iss_cls,
    output logic [RW-1:0]  iss_dst,
    output logic           iss_dslot
);

    localparam int MAXLAT = (LAT_AA > LAT_LA) ? LAT_AA : LAT_LA;
    localparam int CW     = (MAXLAT < 1) ? 1 : $clog2(MAXLAT + 1);

    icls_e                    cls;
    icls_e                    iss_cls_e;
    logic                     hazard;
    logic                     acc;
    logic                     wr_en;
    logic [CW-1:0]            wr_lat;
    logic [NREG-1:0][CW-1:0]  cnt;
    logic [NREG-1:0]          is_ld;

    // Decode the class and form accept / write controls.
    always_comb begin
        cls      = icls_e'(in_cls);
        stall    = hazard;
        in_ready = !hazard;
        acc      = in_valid && !hazard;
        wr_en    = acc && writes_fp(cls);
        wr_lat   = (cls == CL_FLD) ? CW'(LAT_LA) : CW'(LAT_AA);
    end

    ilk_scoreboard #(.NREG(NREG), .CW(CW)) i_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (in_dst),
        .wr_lat (wr_lat),
        .wr_ld  (cls == CL_FLD),
        .cnt    (cnt),
        .is_ld  (is_ld)
    );

    ilk_hazard #(.NREG(NREG), .CW(CW), .LAT_AA(LAT_AA), .LAT_AS(LAT_AS),
                 .LAT_LA(LAT_LA), .LAT_LS(LAT_LS)) i_hz (
        .in_valid (in_valid),
        .cls      (cls),
        .src_a    (in_src_a),
        .src_b    (in_src_b),
        .cnt      (cnt),
        .is_ld    (is_ld),
        .hazard   (hazard)
    );

    ilk_issue_reg #(.RW(RW)) i_iss (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .cls       (cls),
        .dst       (in_dst),
        .iss_valid (iss_valid),
        .iss_cls   (iss_cls_e),
        .iss_dst   (iss_dst),
        .iss_dslot (iss_dslot)
    );

    assign iss_cls = iss_cls_e;

    AST_NO_STALL_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !stall); // R1
    AST_BUBBLE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !iss_valid); // R8
    AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (iss_valid && iss_cls == $past(in_cls))); // R9
    AST_INT_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cls == 3'd0 || in_cls == 3'd4 || in_cls > 3'd4) |-> !stall); // R7
    AST_DSLOT_AFTER_BR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_cls == 3'd4) |=> ##1 iss_dslot); // R10

endmodule

// File: tb/test_fp_interlock.sv
`timescale 1ns/1ps
module test_fp_interlock;

    localparam int NREG = 32;
    localparam int RW   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_cls = '0;
    logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic          in_ready, stall, iss_valid, iss_dslot;
    logic [2:0]    iss_cls;
    logic [RW-1:0] iss_dst;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    fp_interlock i_fp_interlock (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_ready(in_ready), .stall(stall), .iss_valid(iss_valid),
        .iss_cls(iss_cls), .iss_dst(iss_dst), .iss_dslot(iss_dslot)
    );

    // Bench model: acceptance cycle and kind of the last FP producer.
    int  t_iss [NREG];
    bit  m_ld  [NREG];
    bit  m_ok  [NREG];
    int  cyc = 0;
    bit  e_v = 0, e_ds = 0;
    int  e_cls = 0, e_dst = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int pair_lat(bit prod_ld, bit cons_alu);
        if (!prod_ld) return cons_alu ? 3 : 2;
        return cons_alu ? 1 : 0;
    endfunction

    function automatic bit busy(int r, bit cons_alu);
        return m_ok[r] && ((cyc - t_iss[r]) <= pair_lat(m_ld[r], cons_alu));
    endfunction

    function automatic bit model_hz(int c, int a, int b);
        if (c == 1) return busy(a, 1) || busy(b, 1);
        if (c == 3) return busy(b, 0);
        return 0;
    endfunction

    // One cycle: drive, check outputs, advance the model.
    task automatic step(input bit v, input int c, input int d, input int a,
                        input int b, input string tag, output bit st);
        bit es, nd;
        @(negedge clk);
        in_valid = v; in_cls = c[2:0]; in_dst = d[RW-1:0];
        in_src_a = a[RW-1:0]; in_src_b = b[RW-1:0];
        #1;
        es = v && model_hz(c, a, b);
        chk(stall == es, {tag, " stall"}, int'(stall), int'(es));
        chk(in_ready == !es, "R8 in_ready", int'(in_ready), int'(!es));
        chk(iss_valid == e_v, e_v ? "R9 iss_valid" : "R8 empty slot",
            int'(iss_valid), int'(e_v));
        if (e_v) begin
            chk(iss_cls == e_cls[2:0], "R9 iss_cls", int'(iss_cls), e_cls);
            chk(iss_dst == e_dst[RW-1:0], "R9 iss_dst", int'(iss_dst), e_dst);
        end
        chk(iss_dslot == e_ds, "R10 iss_dslot", int'(iss_dslot), int'(e_ds));
        nd    = e_v && (e_cls == 4);
        e_v   = v && !es;
        e_cls = c; e_dst = d; e_ds = nd;
        if (v && !es && (c == 1 || c == 2)) begin
            t_iss[d] = cyc; m_ld[d] = (c == 2); m_ok[d] = 1;
        end
        cyc++;
        st = es;
    endtask

    task automatic issue(input int c, input int d, input int a, input int b,
                         input string tag, output int nst);
        bit st;
        nst = 0;
        for (int k = 0; k < 12; k++) begin
            step(1, c, d, a, b, tag, st);
            if (!st) break;
            nst++;
        end
    endtask

    task automatic idle(input int n);
        bit st;
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, "idle", st);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n, c, d, a, b;
        bit st, v, pend;
        void'($urandom(32'd1234));
        for (int r = 0; r < NREG; r++) begin
            m_ok[r] = 0; m_ld[r] = 0; t_iss[r] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: first instruction after reset reads a register, no stall.
        issue(1, 2, 1, 1, "R1 after reset", n);
        chk(n == 0, "R1 stall count", n, 0);
        idle(5);

        issue(1, 1, 2, 3, "R2 producer", n);
        issue(1, 4, 1, 5, "R2 consumer", n);
        chk(n == 3, "R2 alu->alu stalls", n, 3);
        idle(5);

        issue(1, 6, 2, 3, "R3 producer", n);
        issue(3, 0, 6, 6, "R3 store", n);
        chk(n == 2, "R3 alu->store stalls", n, 2);
        idle(5);

        issue(2, 7, 1, 0, "R4 load", n);
        issue(1, 8, 7, 3, "R4 consumer", n);
        chk(n == 1, "R4 load->alu stalls", n, 1);
        idle(5);

        issue(2, 9, 1, 0, "R5 load", n);
        issue(3, 0, 2, 9, "R5 store", n);
        chk(n == 0, "R5 load->store stalls", n, 0);
        idle(5);

        for (int k = 0; k < 4; k++) begin
            issue(1, 16 + k, 20, 21, "R6 independent", n);
            chk(n == 0, "R6 back-to-back", n, 0);
        end
        idle(5);

        issue(0, 10, 3, 3, "R7 int write", n);
        issue(1, 11, 10, 10, "R7 fp read of same index", n);
        chk(n == 0, "R7 no cross-file hazard", n, 0);
        issue(1, 12, 2, 3, "R7 fp write", n);
        issue(3, 0, 12, 13, "R7 store addr alias", n);
        chk(n == 0, "R7 store address ignored", n, 0);
        issue(0, 14, 12, 12, "R7 int read alias", n);
        chk(n == 0, "R7 int op never stalls", n, 0);
        idle(5);

        issue(4, 0, 1, 0, "R10 branch", n);
        idle(2);
        issue(4, 0, 1, 0, "R10 branch", n);
        issue(1, 22, 20, 21, "R10 filled slot", n);
        issue(4, 0, 1, 0, "R10 branch", n);
        issue(4, 0, 1, 0, "R10 branch in slot", n);
        idle(3);

        issue(1, 24, 2, 3, "R11 first producer", n);
        idle(2);
        issue(1, 24, 2, 3, "R11 second producer", n);
        issue(1, 25, 24, 3, "R11 reader", n);
        chk(n == 3, "R11 restart from newer", n, 3);
        idle(5);
        issue(1, 26, 2, 3, "R11 alu producer", n);
        issue(2, 26, 1, 0, "R11 load replaces", n);
        issue(1, 27, 26, 3, "R11 reader", n);
        chk(n == 1, "R11 newer class wins", n, 1);
        idle(5);

        // R6 random pairs over a small register pool.
        pend = 0; c = 0; d = 0; a = 0; b = 0;
        for (int k = 0; k < 4000; k++) begin
            if (!pend) begin
                v = ($urandom % 5) != 0;
                c = $urandom % 5; d = $urandom % 4;
                a = $urandom % 4; b = $urandom % 4;
            end
            step(v, c, d, a, b, "R6 random pairs", st);
            pend = v && st;
        end
        idle(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule